// File: doc/BRIEF.md
# Power-Rail Enable Sequencing Controller

This block decides when a system's power rails come up and when they go down, and in which order. An internal enable state is set by one of two events: a rising edge on the power-good input, which makes the first application of power turn the system on, or an enable request that stays asserted for a full qualification period. The request can arrive on an active-high input or on an active-low input; the unused one is held at its inactive level. An active-low disable input clears the enable state and has priority over both set events.

Two outputs follow the enable state in mirrored order. The front-end supply enable `fe_en` rises at once and the low-voltage rail enable `lv_en` follows after an on-gap. On the way down, `lv_en` drops at once and `fe_en` follows after an off-gap. All timing is counted in ticks of a slow timebase, which a prescaler derives from the system clock. The default timebase is 6.25 kHz; the default qualification count and both gaps are 94 ticks, about 15 ms.

The output sequencer has four states. `SEQ_OFF` drives both enables low. `SEQ_RAMP_UP` drives `fe_en` high, `lv_en` low, and counts the on-gap. `SEQ_ON` drives both high. `SEQ_RAMP_DOWN` drives `fe_en` high, `lv_en` low, and counts the off-gap. It has these transitions:
- **start**: `SEQ_OFF` to `SEQ_RAMP_UP` when the enable state is set.
- **up-done**: `SEQ_RAMP_UP` to `SEQ_ON` on the last on-gap tick.
- **up-abort**: `SEQ_RAMP_UP` to `SEQ_RAMP_DOWN` when the enable state clears.
- **stop**: `SEQ_ON` to `SEQ_RAMP_DOWN` when the enable state clears.
- **down-done**: `SEQ_RAMP_DOWN` to `SEQ_OFF` on the last off-gap tick.
- **down-abort**: `SEQ_RAMP_DOWN` to `SEQ_RAMP_UP` when the enable state is set again.

Every entry into a ramp state restarts the gap counter.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset with idle inputs (`pgood`=0, `en_req`=0, `en_req_n`=1, `dis_n`=1), both `fe_en` and `lv_en` are 0.
- R2: A 0-to-1 change on `pgood`, with `dis_n` high, sets the enable state; `fe_en` rises within 6 clock cycles. A falling `pgood` has no effect.
- R3: A request sets the enable state once it has been seen asserted on `QUAL_TICKS` consecutive ticks, where one tick occurs every `TICK_DIV` clocks.
- R4: If the request drops before the count completes, the qualification count returns to zero. Separate short requests do not add up, and they leave `fe_en` at 0.
- R5: Once set, the enable state and both outputs stay high however the request inputs toggle. Only `dis_n`=0 clears it.
- R6: `en_req_n`=0 is a request equivalent to `en_req`=1. Either source can qualify on its own.
- R7: While `dis_n` is low, the enable state is held clear and every set event is discarded, including one that falls in the same cycle. A request that qualified during disable must be released and qualified again.
- R8: When the enable state sets from off, `fe_en` rises first. `lv_en` follows after `ON_GAP_TICKS` ticks.
- R9: When the enable state clears from on, `lv_en` falls within 6 cycles of `dis_n` falling. `fe_en` follows after `OFF_GAP_TICKS` ticks.
- R10: `lv_en` is never 1 while `fe_en` is 0. A change of the enable state during a gap restarts the gap count toward the new target: an aborted ramp-up keeps `lv_en` low and holds `fe_en` for a full off-gap, and an aborted ramp-down keeps `fe_en` high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgood | input | 1 | Power-good input, asynchronous; its rising edge sets the enable state |
| en_req | input | 1 | Active-high enable request, asynchronous |
| en_req_n | input | 1 | Active-low enable request, asynchronous; hold high when unused |
| dis_n | input | 1 | Active-low disable, asynchronous; clears the enable state |
| fe_en | output | 1 | Front-end supply enable: first on, last off |
| lv_en | output | 1 | Low-voltage rail enable: last on, first off |

## Verification
Disable and a set event can fall in the same cycle. The bench provokes this by holding `dis_n` low while `pgood` rises and while a request is held for longer than the qualification period. It then judges at the outputs that `fe_en` never rises, and that it stays low after `dis_n` is released while the request is still held. A second overlap happens when the enable state flips while a gap counter is running. The bench drives `dis_n` low during a ramp-up, and raises `pgood` during a ramp-down. A monitor running on every cycle then confirms that `lv_en` never leads `fe_en`.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF       = 2'd0,
        SEQ_RAMP_UP   = 2'd1,
        SEQ_ON        = 2'd2,
        SEQ_RAMP_DOWN = 2'd3
    } seq_state_e;

    // counter width able to hold values 0..n-1
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pwrseq_tick.sv
module pwrseq_tick
    import pwrseq_pkg::*;
#(
    parameter int TICK_DIV = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = cnt_w(TICK_DIV);

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (pre_cnt == LAST) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + PW'(1);
                end
            end

            assign tick = (pre_cnt == LAST);

            // R3
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/pwrseq_qual.sv
module pwrseq_qual
    import pwrseq_pkg::*;
#(
    parameter int QUAL_TICKS = 94
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic done
);
    localparam int QW = cnt_w(QUAL_TICKS + 1);
    localparam logic [QW-1:0] Q_FULL = QW'(QUAL_TICKS);
    localparam logic [QW-1:0] Q_LAST = QW'(QUAL_TICKS - 1);

    logic [QW-1:0] q_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cnt <= '0;
            done  <= 1'b0;
        end else if (!req) begin
            q_cnt <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick && q_cnt != Q_FULL) begin
                q_cnt <= q_cnt + QW'(1);
                if (q_cnt == Q_LAST) begin
                    done <= 1'b1;
                end
            end
        end
    end

    // R3
    done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req));

    // R4
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (q_cnt == '0) && !done);
endmodule

// File: rtl/pwrseq_order.sv
module pwrseq_order
    import pwrseq_pkg::*;
#(
    parameter int ON_GAP_TICKS  = 94,
    parameter int OFF_GAP_TICKS = 94
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic latch,
    output logic fe_en,
    output logic lv_en
);
    localparam int MAX_GAP = (ON_GAP_TICKS > OFF_GAP_TICKS) ? ON_GAP_TICKS : OFF_GAP_TICKS;
    localparam int GW = cnt_w(MAX_GAP);
    localparam logic [GW-1:0] ON_LAST  = GW'(ON_GAP_TICKS - 1);
    localparam logic [GW-1:0] OFF_LAST = GW'(OFF_GAP_TICKS - 1);

    seq_state_e    state, state_nx;
    logic [GW-1:0] gap_cnt, gap_nx;

    always_comb begin
        state_nx = state;
        gap_nx   = gap_cnt;
        unique case (state)
            SEQ_OFF: begin
                if (latch) begin
                    state_nx = SEQ_RAMP_UP;
                    gap_nx   = '0;
                end
            end
            SEQ_RAMP_UP: begin
                if (!latch) begin
                    state_nx = SEQ_RAMP_DOWN;
                    gap_nx   = '0;
                end else if (tick) begin
                    if (gap_cnt == ON_LAST) begin
                        state_nx = SEQ_ON;
                        gap_nx   = '0;
                    end else begin
                        gap_nx = gap_cnt + GW'(1);
                    end
                end
            end
            SEQ_ON: begin
                if (!latch) begin
                    state_nx = SEQ_RAMP_DOWN;
                    gap_nx   = '0;
                end
            end
            SEQ_RAMP_DOWN: begin
                if (latch) begin
                    state_nx = SEQ_RAMP_UP;
                    gap_nx   = '0;
                end else if (tick) begin
                    if (gap_cnt == OFF_LAST) begin
                        state_nx = SEQ_OFF;
                        gap_nx   = '0;
                    end else begin
                        gap_nx = gap_cnt + GW'(1);
                    end
                end
            end
            default: begin
                state_nx = SEQ_OFF;
                gap_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_OFF;
            gap_cnt <= '0;
        end else begin
            state   <= state_nx;
            gap_cnt <= gap_nx;
        end
    end

    // outputs, registered alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_en <= 1'b0;
            lv_en <= 1'b0;
        end else begin
            fe_en <= (state_nx != SEQ_OFF);
            lv_en <= (state_nx == SEQ_ON);
        end
    end

    // R10
    lv_under_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lv_en |-> fe_en);

    // R8
    lv_rise_after_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_en) |-> $past(fe_en));

    // R9
    fe_fall_after_lv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe_en) |-> $past(!lv_en));

    // R10
    ramp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RAMP_UP && !latch) |=> fe_en && !lv_en);
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl #(
    parameter int TICK_DIV      = 20000,
    parameter int QUAL_TICKS    = 94,
    parameter int ON_GAP_TICKS  = 94,
    parameter int OFF_GAP_TICKS = 94
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pgood,
    input  logic en_req,
    input  logic en_req_n,
    input  logic dis_n,
    output logic fe_en,
    output logic lv_en
);
    // bit order: {dis_n, en_req_n, en_req, pgood}
    localparam logic [3:0] SYNC_RST = 4'b1100;

    logic [3:0] raw_in, syn_in;
    logic       pg_s, req_s, req_n_s, dis_n_s;
    logic       pg_prev, pg_rise;
    logic       tick, qual_done, set_evt, latch;

    assign raw_in = {dis_n, en_req_n, en_req, pgood};

    pwrseq_sync #(.W(4), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {dis_n_s, req_n_s, req_s, pg_s} = syn_in;

    pwrseq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pwrseq_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .req   (req_s | ~req_n_s),
        .done  (qual_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_prev <= 1'b0;
        end else begin
            pg_prev <= pg_s;
        end
    end

    assign pg_rise = pg_s & ~pg_prev;
    assign set_evt = pg_rise | qual_done;

    // enable state: disable has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch <= 1'b0;
        end else if (!dis_n_s) begin
            latch <= 1'b0;
        end else if (set_evt) begin
            latch <= 1'b1;
        end
    end

    pwrseq_order #(
        .ON_GAP_TICKS  (ON_GAP_TICKS),
        .OFF_GAP_TICKS (OFF_GAP_TICKS)
    ) u_order (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .latch (latch),
        .fe_en (fe_en),
        .lv_en (lv_en)
    );

    // R7
    dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_n_s |=> !latch);

    // R2
    pg_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_rise && dis_n_s) |=> latch);

    // R5
    latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && dis_n_s) |=> latch);
endmodule

// File: tb/test_pwrseq_ctrl.sv
module test_pwrseq_ctrl;
    localparam int DIV  = 4;
    localparam int QUAL = 6;
    localparam int ONG  = 5;
    localparam int OFFG = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pgood = 1'b0;
    logic en_req = 1'b0;
    logic en_req_n = 1'b1;
    logic dis_n = 1'b1;
    logic fe_en, lv_en;

    int checks = 0;
    int errors = 0;
    int order_viol = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    pwrseq_ctrl #(
        .TICK_DIV(DIV), .QUAL_TICKS(QUAL),
        .ON_GAP_TICKS(ONG), .OFF_GAP_TICKS(OFFG)
    ) i_pwrseq_ctrl (
        .clk(clk), .rst_n(rst_n), .pgood(pgood), .en_req(en_req),
        .en_req_n(en_req_n), .dis_n(dis_n), .fe_en(fe_en), .lv_en(lv_en)
    );

    // R10 order monitor
    always @(negedge clk) begin
        if (rst_n && lv_en && !fe_en) order_viol++;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // which: 0 = fe_en, 1 = lv_en
    task automatic wait_sig(input int which, input logic val, input int lim, output int n);
        n = 0;
        while (((which == 0) ? fe_en : lv_en) !== val && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic shut_down;
        int n;
        @(negedge clk);
        dis_n = 1'b0;
        wait_sig(1, 1'b0, 10, n);
        check_rng("R9 lv_en falls quickly", n, 0, 6);
        check_eq("R9 fe_en still high when lv_en falls", int'(fe_en), 1);
        wait_sig(0, 1'b0, 200, n);
        check_rng("R9 off gap", n, (OFFG - 1) * DIV + 1, OFFG * DIV + 2);
        dis_n = 1'b1;
        idle(5);
    endtask

    task automatic t_reset;
        idle(3);
        check_eq("R1 fe_en in reset", int'(fe_en), 0);
        check_eq("R1 lv_en in reset", int'(lv_en), 0);
        rst_n = 1'b1;
        idle(40);
        check_eq("R1 fe_en idle", int'(fe_en), 0);
        check_eq("R1 lv_en idle", int'(lv_en), 0);
    endtask

    task automatic t_pgood_on;
        int n;
        pgood = 1'b1;
        wait_sig(0, 1'b1, 20, n);
        check_rng("R2 fe_en after pgood rise", n, 1, 6);
        check_eq("R8 lv_en low at fe_en rise", int'(lv_en), 0);
        wait_sig(1, 1'b1, 200, n);
        check_rng("R8 on gap", n, (ONG - 1) * DIV + 1, ONG * DIV + 2);
        shut_down();
        pgood = 1'b0;
        idle(20);
        check_eq("R2 pgood fall ignored", int'(fe_en), 0);
    endtask

    task automatic t_req_short;
        en_req = 1'b1;
        idle((QUAL - 2) * DIV);
        en_req = 1'b0;
        idle(60);
        check_eq("R4 short request", int'(fe_en), 0);
        for (int k = 0; k < 3; k++) begin
            en_req = 1'b1;
            idle((QUAL - 2) * DIV);
            en_req = 1'b0;
            idle(2 * DIV);
        end
        idle(40);
        check_eq("R4 split requests do not add up", int'(fe_en), 0);
    endtask

    task automatic t_req_long;
        int n;
        en_req = 1'b1;
        wait_sig(0, 1'b1, 200, n);
        check_rng("R3 qualification time", n, (QUAL - 1) * DIV, QUAL * DIV + 8);
        for (int k = 0; k < 6; k++) begin
            en_req = ~en_req;
            idle(3);
        end
        en_req = 1'b0;
        idle((ONG + 2) * DIV);
        check_eq("R5 fe_en holds", int'(fe_en), 1);
        check_eq("R5 lv_en holds", int'(lv_en), 1);
        shut_down();
    endtask

    task automatic t_req_n;
        int n;
        en_req_n = 1'b0;
        wait_sig(0, 1'b1, 200, n);
        check_rng("R6 active-low request qualifies", n, (QUAL - 1) * DIV, QUAL * DIV + 8);
        en_req_n = 1'b1;
        wait_sig(1, 1'b1, 200, n);
        check_eq("R6 lv_en follows", int'(lv_en), 1);
        shut_down();
    endtask

    task automatic t_dis_wins;
        dis_n = 1'b0;
        idle(6);
        pgood = 1'b1;
        en_req = 1'b1;
        idle((QUAL + 3) * DIV);
        check_eq("R7 set events during disable", int'(fe_en), 0);
        dis_n = 1'b1;
        idle((QUAL + 3) * DIV);
        check_eq("R7 stale request after disable", int'(fe_en), 0);
        en_req = 1'b0;
        pgood = 1'b0;
        idle(10);
        check_eq("R7 still off", int'(fe_en), 0);
    endtask

    task automatic t_abort;
        int n;
        int fe_drop;
        // aborted ramp-up
        pgood = 1'b1;
        wait_sig(0, 1'b1, 20, n);
        idle(2);
        dis_n = 1'b0;
        idle(6);
        dis_n = 1'b1;
        wait_sig(0, 1'b0, 200, n);
        check_rng("R10 full off gap after aborted ramp-up", n + 6, (OFFG - 1) * DIV + 2, OFFG * DIV + 7);
        check_eq("R10 lv_en stayed low", int'(lv_en), 0);
        pgood = 1'b0;
        idle(10);
        // aborted ramp-down
        pgood = 1'b1;
        wait_sig(1, 1'b1, 200, n);
        pgood = 1'b0;
        dis_n = 1'b0;
        wait_sig(1, 1'b0, 10, n);
        dis_n = 1'b1;
        idle(4);
        pgood = 1'b1;
        fe_drop = 0;
        n = 0;
        while (lv_en !== 1'b1 && n < 200) begin
            @(negedge clk);
            if (!fe_en) fe_drop++;
            n++;
        end
        check_eq("R10 fe_en kept high in aborted ramp-down", fe_drop, 0);
        check_eq("R10 lv_en back on", int'(lv_en), 1);
        shut_down();
        pgood = 1'b0;
        idle(5);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_pgood_on();
        t_req_short();
        t_req_long();
        t_req_n();
        t_dis_wins();
        t_abort();
        check_eq("R10 lv_en never without fe_en", order_viol, 0);
        finish_run();
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule